// File: doc/BRIEF.md
# Dual-Phase Switching Clock Generator

This block derives the start-of-cycle timing for two interleaved converter channels from a fast reference clock. The switching source is either a free-running oscillator input or an external clock arriving on the sync pin. The selected source is halved to form an internal switching clock. Channel 1 receives a one-cycle start pulse on each rising transition of that clock. Channel 2 receives one on each falling transition, so the two channels run half a switching period apart.

A clock output lets a second controller lock to this one. When the sync pin is held low, the clock output equals the switching clock. When the sync pin is held high, the clock output runs at twice the switching rate and lags channel 1 by a quarter of a switching period. When edges appear on the sync pin, the block follows them as a slave: the switching clock becomes the sync clock divided by two, and the clock output matches channel 1. If no sync edge arrives within a programmable window of reference cycles, the block returns to the static-level master behaviour.

Top module: `dual_phase_clkgen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `ch1_start`, `ch2_start` and `cko` are low.
- R2: As a master, with the oscillator toggling every H reference cycles, `ch1_start` pulses exactly every 4H cycles. This is one pulse per two oscillator rising edges.
- R3: `ch2_start` pulses with the same period as `ch1_start` and lands exactly half a switching period (2H cycles) after each channel 1 pulse.
- R4: Each start pulse is exactly one reference cycle wide, and the two start pulses are never high in the same cycle.
- R5: With the sync pin held low, `cko` equals the switching clock. It is high in every cycle that carries a `ch1_start` pulse, low in every cycle that carries a `ch2_start` pulse, and rises in the `ch1_start` cycle.
- R6: With the sync pin held high, `cko` toggles at the oscillator rate, giving two rising edges per switching period. It is low in each `ch1_start` cycle, and each of its rises comes H cycles (a quarter switching period) after a `ch1_start` pulse or after a `ch2_start` pulse.
- R7: Any sync edge selects external-clock mode in the next cycle. With sync toggling every S cycles, `ch1_start` then pulses every 4S cycles, `ch2_start` falls 2S cycles later, and `cko` is high in each `ch1_start` cycle.
- R8: When no sync edge is seen for `sync_window` reference cycles, the block returns to oscillator-driven master timing, and the static sync level chooses R5 or R6.
- R9: While `enable` is low, no start pulses are issued, `cko` is low and the divider is returned to its low phase. After re-enabling, the first start pulse is always on channel 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all logic is synchronous to its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | High runs the generator; low parks the divider and silences all outputs |
| osc_in | input | 1 | Free-running oscillator, asynchronous to `clk` |
| sync_in | input | 1 | Static mode level or external clock, asynchronous to `clk` |
| sync_window | input | WIN_W | Reference cycles without a sync edge before external mode is dropped |
| ch1_start | output | 1 | One-cycle start pulse for channel 1 |
| ch2_start | output | 1 | One-cycle start pulse for channel 2 |
| cko | output | 1 | Clock output for a slave controller |

## Verification
A falling `enable` can land in the same reference cycle as a source rising edge that would otherwise issue a start pulse and toggle the divider. The disable input must win. The bench provokes this by sweeping the cycle in which `enable` drops across every offset of a full switching period after a channel 1 pulse. It then judges at the ports that no pulse escapes, that `cko` stays low, and that the first pulse after re-enabling belongs to channel 1, which shows the divider phase was reset and not left half-toggled.

// File: rtl/clkgen_pkg.sv
// Package: shared clock-source selection type for the dual-phase generator.
package clkgen_pkg;
    typedef enum logic [1:0] {
        SRC_INPHASE = 2'd0,  // master, clock output follows switching clock
        SRC_QUAD    = 2'd1,  // master, clock output at double rate, quarter lag
        SRC_EXT     = 2'd2   // slave, switching clock taken from sync pin
    } clk_mode_e;
endpackage

// File: rtl/clkgen_sync_edge.sv
// Module: clkgen_sync_edge
// Brings an asynchronous level into the clk domain through STAGES flops and
// reports its synchronized level and any change of it. Assumes the input
// stays stable for more than one clk period per level. The change flag is
// held off until the pipeline has filled after reset, so a static input
// level never reads as an edge.
module clkgen_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic change
);
    logic [STAGES:0] pipe;
    logic [STAGES:0] fill;

    // Purpose: shift the raw input through the synchronizer and history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], din};
    end

    // Purpose: mark when every pipeline stage holds a genuine sample.
    always_ff @(posedge clk) begin
        if (!rst_n) fill <= '0;
        else        fill <= {fill[STAGES-1:0], 1'b1};
    end

    assign level  = pipe[STAGES-1];
    assign change = fill[STAGES] & (pipe[STAGES-1] ^ pipe[STAGES]);
endmodule

// File: rtl/clkgen_sync_detect.sv
// Module: clkgen_sync_detect
// Decides whether the sync pin carries a clock. Any synchronized edge sets
// external mode; a run of `window` cycles without one clears it. Assumes the
// window is longer than the slowest expected sync half-period.
module clkgen_sync_detect #(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_edge,
    input  logic [WIN_W-1:0] window,
    output logic             ext_mode
);
    logic [WIN_W-1:0] quiet_cnt;

    // Purpose: count quiet cycles since the last sync edge and track the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_cnt <= '1;
            ext_mode  <= 1'b0;
        end else if (sync_edge) begin
            quiet_cnt <= '0;
            ext_mode  <= 1'b1;
        end else if (quiet_cnt >= window) begin
            ext_mode  <= 1'b0;
        end else begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    // R7: an observed sync edge always selects external mode next cycle.
    assert_edge_locks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_edge |=> ext_mode);
endmodule

// File: rtl/clkgen_phase_div.sv
// Module: clkgen_phase_div
// Halves the selected source into the switching clock, emits the two channel
// start pulses on its opposite transitions, and forms the clock output for
// the current mode. Assumes src_rise is a single-cycle flag and osc_level is
// the synchronized oscillator aligned with it.
module clkgen_phase_div
    import clkgen_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      src_rise,
    input  logic      osc_level,
    input  clk_mode_e mode,
    output logic      ch1_start,
    output logic      ch2_start,
    output logic      cko
);
    logic sw_clk;
    logic sw_next;

    // Purpose: next switching-clock value after this cycle's source edge.
    always_comb begin
        sw_next = src_rise ? ~sw_clk : sw_clk;
    end

    // Purpose: divider state, start pulses and clock output registers.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            sw_clk    <= 1'b0;
            ch1_start <= 1'b0;
            ch2_start <= 1'b0;
            cko       <= 1'b0;
        end else begin
            sw_clk    <= sw_next;
            ch1_start <= src_rise & ~sw_clk;
            ch2_start <= src_rise &  sw_clk;
            cko       <= (mode == SRC_QUAD) ? ~osc_level : sw_next;
        end
    end

    // R4: a start pulse never lasts longer than one cycle.
    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ch1_start || ch2_start) |=> !(ch1_start || ch2_start));
    // R4: the two channels never start in the same cycle.
    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ch1_start && ch2_start));
    // R9: a low enable leaves every output low after the edge.
    assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!ch1_start && !ch2_start && !cko));
    // R3: channel 2 start only follows channel 1 by a later cycle.
    assert_ch2_not_after_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ch2_start) |-> !$past(ch1_start));
endmodule

// File: rtl/dual_phase_clkgen.sv
// Module: dual_phase_clkgen (top)
// Synchronizes the oscillator and sync pins, detects an external sync
// clock, selects the switching source and mode, and drives the two channel
// start pulses plus the slave clock output. Assumes both pin inputs are
// slower than a quarter of the clk rate.
module dual_phase_clkgen
    import clkgen_pkg::*;
#(
    parameter int WIN_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             osc_in,
    input  logic             sync_in,
    input  logic [WIN_W-1:0] sync_window,
    output logic             ch1_start,
    output logic             ch2_start,
    output logic             cko
);
    logic      osc_level, osc_change;
    logic      sync_level, sync_change;
    logic      ext_mode;
    logic      src_rise;
    clk_mode_e mode;

    clkgen_sync_edge #(.STAGES(SYNC_STAGES)) u_osc_sync (
        .clk(clk), .rst_n(rst_n), .din(osc_in),
        .level(osc_level), .change(osc_change)
    );

    clkgen_sync_edge #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .din(sync_in),
        .level(sync_level), .change(sync_change)
    );

    clkgen_sync_detect #(.WIN_W(WIN_W)) u_detect (
        .clk(clk), .rst_n(rst_n), .sync_edge(sync_change),
        .window(sync_window), .ext_mode(ext_mode)
    );

    // Purpose: choose the clocking mode and the rising edge that drives the divider.
    always_comb begin
        if (ext_mode) begin
            mode     = SRC_EXT;
            src_rise = sync_change & sync_level;
        end else begin
            mode     = sync_level ? SRC_QUAD : SRC_INPHASE;
            src_rise = osc_change & osc_level;
        end
    end

    clkgen_phase_div u_div (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .src_rise(src_rise), .osc_level(osc_level), .mode(mode),
        .ch1_start(ch1_start), .ch2_start(ch2_start), .cko(cko)
    );
endmodule

// File: tb/dual_phase_clkgen_tb.sv
module dual_phase_clkgen_tb;
    localparam int WIN_W = 16;
    localparam int WINDOW = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic osc_in = 1'b0;
    logic sync_in = 1'b0;
    logic [WIN_W-1:0] sync_window = WIN_W'(WINDOW);
    logic ch1_start, ch2_start, cko;

    int osc_half = 3, osc_cnt = 0;
    int sync_half = 4, sync_cnt = 0;
    logic sync_run = 1'b0, sync_lvl = 1'b0;
    int checks = 0, fails = 0;
    bit done = 0;

    // measurement statistics
    int cyc = 0;
    bit meas = 0;
    int n1, n2, t1, t2, p1min, p1max, p2min, p2max, offmin, offmax;
    int wide, both, ck1hi, ck2hi, rises, rofmin, rofmax;
    logic prev1, prev2, prevck;

    dual_phase_clkgen #(.WIN_W(WIN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .osc_in(osc_in),
        .sync_in(sync_in), .sync_window(sync_window),
        .ch1_start(ch1_start), .ch2_start(ch2_start), .cko(cko)
    );

    always #2 clk = ~clk;

    // stimulus generators, driven away from the active edge
    always @(negedge clk) begin
        if (osc_cnt >= osc_half - 1) begin osc_in = ~osc_in; osc_cnt = 0; end
        else osc_cnt++;
        if (sync_run) begin
            if (sync_cnt >= sync_half - 1) begin sync_in = ~sync_in; sync_cnt = 0; end
            else sync_cnt++;
        end else begin
            sync_in = sync_lvl; sync_cnt = 0;
        end
    end

    // monitor
    always @(negedge clk) begin
        cyc++;
        if (meas) begin
            if (ch1_start && prev1) wide++;
            if (ch2_start && prev2) wide++;
            if (ch1_start && ch2_start) both++;
            if (ch1_start) begin
                if (n1 > 0) begin
                    if (cyc - t1 < p1min) p1min = cyc - t1;
                    if (cyc - t1 > p1max) p1max = cyc - t1;
                end
                t1 = cyc; n1++;
                if (cko) ck1hi++;
            end
            if (ch2_start) begin
                if (n2 > 0) begin
                    if (cyc - t2 < p2min) p2min = cyc - t2;
                    if (cyc - t2 > p2max) p2max = cyc - t2;
                end
                if (n1 > 0) begin
                    if (cyc - t1 < offmin) offmin = cyc - t1;
                    if (cyc - t1 > offmax) offmax = cyc - t1;
                end
                t2 = cyc; n2++;
                if (cko) ck2hi++;
            end
            if (cko && !prevck && n1 > 0) begin
                rises++;
                if (n2 > 0 && t2 > t1) begin
                    if (cyc - t2 < rofmin) rofmin = cyc - t2;
                    if (cyc - t2 > rofmax) rofmax = cyc - t2;
                end else begin
                    if (cyc - t1 < rofmin) rofmin = cyc - t1;
                    if (cyc - t1 > rofmax) rofmax = cyc - t1;
                end
            end
        end
        prev1 = ch1_start; prev2 = ch2_start; prevck = cko;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic measure(input int n);
        n1 = 0; n2 = 0; t1 = 0; t2 = 0;
        p1min = 1 << 30; p1max = 0; p2min = 1 << 30; p2max = 0;
        offmin = 1 << 30; offmax = 0; wide = 0; both = 0;
        ck1hi = 0; ck2hi = 0; rises = 0; rofmin = 1 << 30; rofmax = 0;
        meas = 1;
        repeat (n) @(negedge clk);
        meas = 0;
    endtask

    // Common period and phase checks for a half-period h of the active source.
    task automatic check_period(input int h, input string tag);
        check(n1 >= 4, {tag, " ch1 pulses seen"}, n1, 4);
        check(p1min == 4*h && p1max == 4*h, {tag, " ch1 period"}, p1max, 4*h);
        check(p2min == 4*h && p2max == 4*h, {tag, " R3 ch2 period"}, p2max, 4*h);
        check(offmin == 2*h && offmax == 2*h, {tag, " R3 ch2 offset"}, offmax, 2*h);
        check(wide == 0 && both == 0, {tag, " R4 pulse shape"}, wide + both, 0);
    endtask

    initial begin
        sync_lvl = 1'b0;
        repeat (5) @(negedge clk);
        // R1: reset state
        check(!ch1_start && !ch2_start && !cko, "R1 during reset",
              {ch1_start, ch2_start, cko}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ch1_start && !ch2_start && !cko, "R1 after reset",
              {ch1_start, ch2_start, cko}, 0);
        enable = 1'b1;

        // R2/R3/R4/R5/R6: master sweep over oscillator half-periods
        foreach (osc_half_list[i]) begin
            osc_half = osc_half_list[i];
            sync_lvl = 1'b0;
            repeat (WINDOW + 20 * osc_half) @(negedge clk);
            measure(40 * osc_half);
            check_period(osc_half, "R2 inphase");
            check(ck1hi == n1 && ck2hi == 0, "R5 cko level at starts", ck1hi - ck2hi, n1);
            check(rofmin == 0 && rofmax == 0, "R5 cko rise at ch1", rofmax, 0);
            check(rises >= n1 - 1 && rises <= n1 + 1, "R5 cko rate", rises, n1);

            sync_lvl = 1'b1;
            repeat (WINDOW + 20 * osc_half) @(negedge clk);
            measure(40 * osc_half);
            check_period(osc_half, "R2 quad");
            check(ck1hi == 0, "R6 cko low at ch1", ck1hi, 0);
            check(rofmin == osc_half && rofmax == osc_half, "R6 cko quarter lag", rofmax, osc_half);
            check(rises >= 2*n1 - 1 && rises <= 2*n1 + 1, "R6 cko double rate", rises, 2*n1);
        end

        // R7: external sync clock at several rates, oscillator left running
        osc_half = 3;
        sync_lvl = 1'b0;
        foreach (sync_half_list[i]) begin
            sync_half = sync_half_list[i];
            sync_run = 1'b1;
            repeat (20 * sync_half + 20) @(negedge clk);
            measure(40 * sync_half);
            check_period(sync_half, "R7 ext");
            check(ck1hi == n1 && ck2hi == 0, "R7 cko in phase", ck1hi, n1);

            // R8: sync stops, block returns to oscillator master timing
            sync_run = 1'b0;
            sync_lvl = 1'b0;
            repeat (WINDOW + 40) @(negedge clk);
            measure(40 * osc_half);
            check_period(osc_half, "R8 fallback");
            check(ck1hi == n1, "R8 inphase cko after fallback", ck1hi, n1);
        end

        // R9: disable swept across every offset of a switching period
        osc_half = 3;
        sync_lvl = 1'b0;
        repeat (WINDOW + 40) @(negedge clk);
        for (int off = 0; off < 4 * 3; off++) begin
            int guard = 0;
            int bad = 0;
            while (!ch1_start && guard < 100) begin @(negedge clk); guard++; end
            repeat (off) @(negedge clk);
            enable = 1'b0;
            repeat (30) begin
                @(negedge clk);
                if (ch1_start || ch2_start || cko) bad++;
            end
            check(bad == 0, "R9 quiet while disabled", bad, 0);
            enable = 1'b1;
            guard = 0;
            while (!ch1_start && !ch2_start && guard < 100) begin @(negedge clk); guard++; end
            check(ch1_start && !ch2_start, "R9 first pulse is ch1",
                  {ch1_start, ch2_start}, 2);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    int osc_half_list[5] = '{2, 3, 4, 5, 7};
    int sync_half_list[3] = '{2, 5, 8};

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule